// File: doc/BRIEF.md
# Value-Prediction Fault Reaction Unit

This unit sits next to the result path of an out-of-order core. For each completing instruction it receives the candidate values from a bank of value predictors, the confidence attached to the prediction, the value the datapath actually produced, and the reorder-buffer tag of the instruction. It takes a majority vote over the candidates and compares the winner with the produced value. It then settles on exactly one reaction. It either forwards a result, asks the pipeline to flush and run the producer and its consumer again, or enters a deceptive reaction. In the deceptive reaction it hands back deliberately corrupted data and raises a one-cycle alarm, and execution is not stopped.

Every reorder-buffer entry owns an 8-bit status counter. The counter counts re-executions of that entry's producer. A nonzero counter marks the entry as under suspected fault injection. Retire and squash notifications from the pipeline clear the counter. The corruption pattern is a register that software-visible logic elsewhere loads through a write strobe.

Top module: `vp_fault_react`

## Requirements
- R1: With three predictors, the voted value is any candidate that at least two predictors agree on. A majority exists only when such a pair exists.
- R2: With a majority, a clean status and a confidence of 99 or more, the output value is the voted value. Neither flushReq nor alarm is raised.
- R3: With a majority, a clean status and a confidence from 91 to 98, flushReq is high for the result cycle and the output value is the produced value.
- R4: With a clean status and a confidence of 90 or less, the output value is the produced value. Neither flushReq nor alarm is raised.
- R5: When no two candidates agree, the confidence is treated as 0. The produced value is returned, flushReq stays low and mismatch stays low.
- R6: Each entry's 8-bit status counter resets to 0. A re-execute notice for the entry increments it, saturating at 255. An input for a tag uses the counter value from before any notice in the same cycle.
- R7: A nonzero status counter for the input tag overrides every confidence rule. The output is the produced value XOR the mask register, alarm is high for that one result cycle, and flushReq stays low.
- R8: A retire or squash notice clears the entry's counter. A clear takes priority over a re-execute notice for the same entry in the same cycle.
- R9: The mask register resets to 0 and loads maskWrData when maskWrEn is high. An input in the same cycle as a write uses the previous mask.
- R10: Every result appears exactly one cycle after the inValid strobe, carrying the input's tag. outValid is low in every other cycle, and flushReq, alarm and mismatch are only high together with outValid. Inputs may arrive on consecutive cycles.
- R11: mismatch is high in a result cycle exactly when a majority exists and the voted value differs from the produced value.
- R12: After reset, outValid, flushReq, alarm and mismatch are low and no entry is suspicious.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction result present this cycle |
| inTag | input | TAG_W | Reorder-buffer tag of the instruction |
| predValues | input | NUM_PRED*DATA_W | Predictor candidates, predictor k in bits [k*DATA_W +: DATA_W] |
| predConf | input | CONF_W | Prediction confidence, unsigned percent |
| producedValue | input | DATA_W | Value from the datapath |
| reexecValid | input | 1 | Producer of an entry re-executed |
| reexecTag | input | TAG_W | Entry of the re-execute notice |
| retireValid | input | 1 | Entry retired |
| retireTag | input | TAG_W | Entry of the retire notice |
| squashValid | input | 1 | Entry flushed by the pipeline |
| squashTag | input | TAG_W | Entry of the squash notice |
| maskWrEn | input | 1 | Load the corruption mask |
| maskWrData | input | DATA_W | New corruption mask |
| outValid | output | 1 | Result valid |
| outTag | output | TAG_W | Tag of the result |
| outValue | output | DATA_W | Final value |
| mismatch | output | 1 | Voted value differed from produced value |
| flushReq | output | 1 | Flush and re-execute request |
| alarm | output | 1 | Deceptive reaction taken |

## Verification
A counter that increments, wraps or clears incorrectly only shows at the ports the next time an input arrives for that tag. The failure is an alarm and a masked value where a forwarded or flushed result was due, or the reverse. The bench therefore follows each notice with an input on the same tag, including a 256-notice run that exposes wrap-around. A wrong vote or band decision shows one cycle after the input as a wrong value, flush or mismatch bit, and each threshold edge (90, 91, 98, 99) gets its own input.

// File: rtl/vpfr_pkg.sv
package vpfr_pkg;
  // strobes from control to datapath, valid in the cycle of inValid
  typedef struct packed {
    logic capture;
    logic selVoted;
    logic selMasked;
  } vpfrStrobe_t;
endpackage

// File: rtl/vpfr_vote.sv
module vpfr_vote #(
  parameter int DATA_W   = 32,
  parameter int NUM_PRED = 3
) (
  input  logic [NUM_PRED*DATA_W-1:0] cands,
  output logic [DATA_W-1:0]          voted,
  output logic                       voteOk
);
  localparam int CNT_W = $clog2(NUM_PRED + 1);
  localparam int NEED  = NUM_PRED / 2 + 1;

  logic [NUM_PRED-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PRED; gi++) begin : g_cand
      logic [CNT_W-1:0] agree;
      always_comb begin
        agree = '0;
        for (int j = 0; j < NUM_PRED; j++) begin
          if (cands[j*DATA_W +: DATA_W] == cands[gi*DATA_W +: DATA_W])
            agree = agree + CNT_W'(1);
        end
      end
      assign hit[gi] = (agree >= CNT_W'(NEED));
    end
  endgenerate

  always_comb begin
    voted  = '0;
    voteOk = 1'b0;
    for (int k = NUM_PRED - 1; k >= 0; k--) begin
      if (hit[k]) begin
        voted  = cands[k*DATA_W +: DATA_W];
        voteOk = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpfr_datapath.sv
module vpfr_datapath
  import vpfr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_PRED = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PRED*DATA_W-1:0] predValues,
  input  logic [DATA_W-1:0]          producedValue,
  input  logic                       maskWrEn,
  input  logic [DATA_W-1:0]          maskWrData,
  input  vpfrStrobe_t                strobe,
  output logic                       voteOk,
  output logic [DATA_W-1:0]          outValue,
  output logic                       mismatch
);
  logic [DATA_W-1:0] voted;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] nextValue;

  vpfr_vote #(.DATA_W(DATA_W), .NUM_PRED(NUM_PRED)) u_vote (
    .cands (predValues),
    .voted (voted),
    .voteOk(voteOk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        maskQ <= '0;
    else if (maskWrEn) maskQ <= maskWrData;
  end

  always_comb begin
    if (strobe.selMasked)     nextValue = producedValue ^ maskQ;
    else if (strobe.selVoted) nextValue = voted;
    else                      nextValue = producedValue;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValue <= '0;
      mismatch <= 1'b0;
    end else begin
      mismatch <= strobe.capture && voteOk && (voted != producedValue);
      if (strobe.capture) outValue <= nextValue;
    end
  end
endmodule

// File: rtl/vpfr_ctrl.sv
module vpfr_ctrl
  import vpfr_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  parameter int STAT_W    = 8,
  parameter int CONF_W    = 7,
  parameter int HI_PCT    = 99,
  parameter int LO_PCT    = 90,
  localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [CONF_W-1:0] predConf,
  input  logic              voteOk,
  input  logic              reexecValid,
  input  logic [TAG_W-1:0]  reexecTag,
  input  logic              retireValid,
  input  logic [TAG_W-1:0]  retireTag,
  input  logic              squashValid,
  input  logic [TAG_W-1:0]  squashTag,
  output vpfrStrobe_t       strobe,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic              flushReq,
  output logic              alarm
);
  localparam logic [STAT_W-1:0] STAT_MAX = '1;

  logic [STAT_W-1:0] statusQ [ROB_DEPTH];
  logic              suspicious;
  logic [CONF_W-1:0] effConf;
  logic              goFlush;
  logic              goAlarm;

  genvar ge;
  generate
    for (ge = 0; ge < ROB_DEPTH; ge++) begin : g_entry
      logic clrHit;
      logic incHit;
      assign clrHit = (retireValid && retireTag == TAG_W'(ge)) ||
                      (squashValid && squashTag == TAG_W'(ge));
      assign incHit = reexecValid && reexecTag == TAG_W'(ge);
      always_ff @(posedge clk) begin
        if (!rst_n)                               statusQ[ge] <= '0;
        else if (clrHit)                          statusQ[ge] <= '0;
        else if (incHit && statusQ[ge] != STAT_MAX) statusQ[ge] <= statusQ[ge] + STAT_W'(1);
      end
    end
  endgenerate

  assign suspicious = (statusQ[inTag] != '0);
  assign effConf    = voteOk ? predConf : '0;

  always_comb begin
    strobe         = '0;
    strobe.capture = inValid;
    goFlush        = 1'b0;
    goAlarm        = 1'b0;
    if (suspicious) begin
      strobe.selMasked = 1'b1;
      goAlarm          = 1'b1;
    end else if (effConf >= CONF_W'(HI_PCT)) begin
      strobe.selVoted = 1'b1;
    end else if (effConf > CONF_W'(LO_PCT)) begin
      goFlush = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outTag   <= '0;
      flushReq <= 1'b0;
      alarm    <= 1'b0;
    end else begin
      outValid <= inValid;
      flushReq <= inValid && goFlush;
      alarm    <= inValid && goAlarm;
      if (inValid) outTag <= inTag;
    end
  end
endmodule

// File: rtl/vp_fault_react.sv
module vp_fault_react
  import vpfr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PRED  = 3,
  parameter int ROB_DEPTH = 16,
  parameter int STAT_W    = 8,
  parameter int CONF_W    = 7,
  localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [TAG_W-1:0]           inTag,
  input  logic [NUM_PRED*DATA_W-1:0] predValues,
  input  logic [CONF_W-1:0]          predConf,
  input  logic [DATA_W-1:0]          producedValue,
  input  logic                       reexecValid,
  input  logic [TAG_W-1:0]           reexecTag,
  input  logic                       retireValid,
  input  logic [TAG_W-1:0]           retireTag,
  input  logic                       squashValid,
  input  logic [TAG_W-1:0]           squashTag,
  input  logic                       maskWrEn,
  input  logic [DATA_W-1:0]          maskWrData,
  output logic                       outValid,
  output logic [TAG_W-1:0]           outTag,
  output logic [DATA_W-1:0]          outValue,
  output logic                       mismatch,
  output logic                       flushReq,
  output logic                       alarm
);
  vpfrStrobe_t strobe;
  logic        voteOk;

  vpfr_ctrl #(.ROB_DEPTH(ROB_DEPTH), .STAT_W(STAT_W), .CONF_W(CONF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inTag(inTag), .predConf(predConf), .voteOk(voteOk),
    .reexecValid(reexecValid), .reexecTag(reexecTag),
    .retireValid(retireValid), .retireTag(retireTag),
    .squashValid(squashValid), .squashTag(squashTag),
    .strobe(strobe), .outValid(outValid), .outTag(outTag),
    .flushReq(flushReq), .alarm(alarm)
  );

  vpfr_datapath #(.DATA_W(DATA_W), .NUM_PRED(NUM_PRED)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .predValues(predValues), .producedValue(producedValue),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .strobe(strobe), .voteOk(voteOk),
    .outValue(outValue), .mismatch(mismatch)
  );
endmodule

// File: rtl/vpfr_checker.sv
module vpfr_checker #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [TAG_W-1:0]  inTag,
  input logic [DATA_W-1:0] producedValue,
  input logic              outValid,
  input logic [TAG_W-1:0]  outTag,
  input logic [DATA_W-1:0] outValue,
  input logic              mismatch,
  input logic              flushReq,
  input logic              alarm,
  input logic              voteOk,
  input logic [DATA_W-1:0] maskQ
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outValid && outTag == $past(inTag)));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq || alarm || mismatch) |-> outValid);
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flushReq, alarm}));
  p_masked_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> (outValue == ($past(producedValue) ^ $past(maskQ))));
  p_flush_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> (outValue == $past(producedValue)));
  p_no_majority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !voteOk) |=> (!flushReq && !mismatch));
endmodule

bind vp_fault_react vpfr_checker #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag),
  .producedValue(producedValue), .outValid(outValid), .outTag(outTag),
  .outValue(outValue), .mismatch(mismatch), .flushReq(flushReq),
  .alarm(alarm), .voteOk(u_dp.voteOk), .maskQ(u_dp.maskQ)
);

// File: tb/vp_fault_react_bench.sv
`timescale 1ns/1ps
module vp_fault_react_bench;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int RD = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [TW-1:0] inTag = '0;
  logic [3*DW-1:0] predValues = '0;
  logic [6:0]    predConf = '0;
  logic [DW-1:0] producedValue = '0;
  logic          reexecValid = 1'b0;
  logic [TW-1:0] reexecTag = '0;
  logic          retireValid = 1'b0;
  logic [TW-1:0] retireTag = '0;
  logic          squashValid = 1'b0;
  logic [TW-1:0] squashTag = '0;
  logic          maskWrEn = 1'b0;
  logic [DW-1:0] maskWrData = '0;
  logic          outValid;
  logic [TW-1:0] outTag;
  logic [DW-1:0] outValue;
  logic          mismatch, flushReq, alarm;

  always #2.5 clk = ~clk;

  vp_fault_react u_vp_fault_react (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag),
    .predValues(predValues), .predConf(predConf), .producedValue(producedValue),
    .reexecValid(reexecValid), .reexecTag(reexecTag),
    .retireValid(retireValid), .retireTag(retireTag),
    .squashValid(squashValid), .squashTag(squashTag),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .outValid(outValid), .outTag(outTag), .outValue(outValue),
    .mismatch(mismatch), .flushReq(flushReq), .alarm(alarm)
  );

  typedef struct {
    logic [DW-1:0] val;
    logic [TW-1:0] tag;
    logic fl, al, mm;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic [7:0]    statM [RD];
  logic [DW-1:0] maskM = '0;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // one cycle of stimulus; expected result built from the requirements
  task automatic step(input logic iv, input logic [TW-1:0] tg,
                      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c,
                      input logic [6:0] cf, input logic [DW-1:0] pv,
                      input logic rx, input logic [TW-1:0] rxt,
                      input logic rt, input logic [TW-1:0] rtt,
                      input logic sq, input logic [TW-1:0] sqt,
                      input logic mw, input logic [DW-1:0] md, input string req);
    exp_t e;
    logic maj;
    logic [DW-1:0] vv;
    logic [6:0] eff;
    @(negedge clk);
    inValid = iv; inTag = tg; predValues = {c, b, a}; predConf = cf; producedValue = pv;
    reexecValid = rx; reexecTag = rxt; retireValid = rt; retireTag = rtt;
    squashValid = sq; squashTag = sqt; maskWrEn = mw; maskWrData = md;
    if (iv) begin
      maj = 1'b1;
      if (a == b || a == c) vv = a;
      else if (b == c) vv = b;
      else begin vv = '0; maj = 1'b0; end
      eff = maj ? cf : 7'd0;
      e.tag = tg; e.req = req; e.fl = 0; e.al = 0;
      e.mm = maj && (vv != pv);
      if (statM[tg] != 0) begin e.val = pv ^ maskM; e.al = 1; end
      else if (eff >= 7'd99) e.val = vv;
      else if (eff > 7'd90) begin e.val = pv; e.fl = 1; end
      else e.val = pv;
      q.push_back(e);
    end
    for (int i = 0; i < RD; i++) begin
      if ((rt && rtt == TW'(i)) || (sq && sqt == TW'(i))) statM[i] = 0;
      else if (rx && rxt == TW'(i) && statM[i] != 8'hFF) statM[i] = statM[i] + 1;
    end
    if (mw) maskM = md;
  endtask

  task automatic give(input logic [TW-1:0] tg, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [DW-1:0] c, input logic [6:0] cf, input logic [DW-1:0] pv,
                      input string req);
    step(1, tg, a, b, c, cf, pv, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic reexec(input logic [TW-1:0] tg);
    step(0, 0, 0, 0, 0, 0, 0, 1, tg, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  // monitor: results appear one cycle after the strobe
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(outValid && outTag == e.tag && outValue == e.val && flushReq == e.fl &&
                alarm == e.al && mismatch == e.mm, e.req,
                $sformatf("got v=%0b tag=%0d val=%h fl=%0b al=%0b mm=%0b exp tag=%0d val=%h fl=%0b al=%0b mm=%0b",
                          outValid, outTag, outValue, flushReq, alarm, mismatch,
                          e.tag, e.val, e.fl, e.al, e.mm));
        end else begin
          check(!outValid && !flushReq && !alarm && !mismatch, "R10",
                $sformatf("idle got v=%0b fl=%0b al=%0b mm=%0b exp all 0",
                          outValid, flushReq, alarm, mismatch));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < RD; i++) statM[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && !flushReq && !alarm && !mismatch, "R12",
          $sformatf("reset got v=%0b fl=%0b al=%0b mm=%0b exp 0", outValid, flushReq, alarm, mismatch));
    @(negedge clk); rst_n = 1'b1;

    // R12: no entry suspicious after reset
    give(2, 32'h11, 32'h11, 32'h11, 7'd100, 32'h11, "R12");
    // R9: mask load
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0F0F_0000, "R9");
    // R2/R11: unanimous, high confidence, differs from produced
    give(1, 32'hAAAA_0001, 32'hAAAA_0001, 32'hAAAA_0001, 7'd100, 32'h1234, "R2");
    // R1: two of three agree, at 99
    give(1, 32'h5, 32'h77, 32'h77, 7'd99, 32'h9, "R1");
    give(1, 32'h42, 32'h13, 32'h42, 7'd99, 32'h9, "R1");
    // R3 band edges, consecutive inputs
    give(2, 32'h8, 32'h8, 32'h1, 7'd98, 32'h3, "R3");
    give(3, 32'h8, 32'h8, 32'h1, 7'd91, 32'h4, "R3");
    give(4, 32'h8, 32'h8, 32'h8, 7'd95, 32'h8, "R11");
    // R4
    give(5, 32'h8, 32'h8, 32'h8, 7'd90, 32'h6, "R4");
    give(5, 32'h8, 32'h8, 32'h8, 7'd0, 32'h7, "R4");
    // R5: no majority
    give(6, 32'h1, 32'h2, 32'h3, 7'd100, 32'hC, "R5");
    give(6, 32'h1, 32'h2, 32'h3, 7'd95, 32'hD, "R5");
    idle();
    // R6/R7: re-execute then suspicious
    reexec(3);
    give(3, 32'h8, 32'h8, 32'h8, 7'd100, 32'hDEAD_BEEF, "R7");
    give(3, 32'h8, 32'h8, 32'h8, 7'd95, 32'h0000_00FF, "R7");
    give(4, 32'h8, 32'h8, 32'h8, 7'd100, 32'h1, "R6");
    // R6: same-cycle notice uses old count
    step(1, 5, 32'h9, 32'h9, 32'h9, 7'd100, 32'h2, 1, 5, 0, 0, 0, 0, 0, 0, "R6");
    give(5, 32'h9, 32'h9, 32'h9, 7'd100, 32'h2, "R6");
    // R8: retire and squash clear
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 1, 5, 0, 0, "R8");
    give(3, 32'h9, 32'h9, 32'h9, 7'd100, 32'h2, "R8");
    give(5, 32'h9, 32'h9, 32'h9, 7'd95, 32'h2, "R8");
    // R8: clear wins over re-execute
    step(0, 0, 0, 0, 0, 0, 0, 1, 6, 1, 6, 0, 0, 0, 0, "R8");
    give(6, 32'h9, 32'h9, 32'h9, 7'd100, 32'h3, "R8");
    // R6: saturation at 255, no wrap after 256 notices
    for (int i = 0; i < 256; i++) reexec(7);
    give(7, 32'h9, 32'h9, 32'h9, 7'd100, 32'h5, "R6");
    // R9: write in same cycle as suspicious input uses old mask, then new
    step(1, 7, 32'h9, 32'h9, 32'h9, 7'd100, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 1, 32'h0000_00F0, "R9");
    give(7, 32'h9, 32'h9, 32'h9, 7'd100, 32'hFFFF_FFFF, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 0, 0, 0, 0, "R8");
    give(7, 32'h9, 32'h9, 32'h9, 7'd100, 32'h5, "R8");
    repeat (3) idle();
    @(posedge clk); #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule